// File: doc/BRIEF.md
# Three-Bank Prioritized Interrupt Controller

This block collects interrupt requests from three 8-bit source groups and presents one winning interrupt number to a processor. The latched group (numbers 0–7) catches rising edges and holds them until software clears them. The level group (numbers 8–15) and the DMA group (numbers 16–23) show their inputs directly. Each group has a status view, a masked request view and a mask register. All of them sit on a small byte-wide register bus. A separate 8-bit fast group has a status view and a mask, and it drives a single fast-interrupt line.

A fixed priority search looks at the level group first, then the DMA group, then the latched group. Inside each group the bits are ranked in a fixed, irregular order. The result is a 5-bit number with a valid flag, so that number 0 can be told apart from no request. The processor interrupt line is the OR of all masked requests in the three numbered groups. Reads are combinational within the access cycle, and writes take effect on the next clock edge. The outputs are plain status pins. They carry no handshake, and the processor takes them as level signals with no back-pressure.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The register address decodes as follows. `addr[5:4]` selects the group: 0 latched, 1 level, 2 DMA, 3 fast. `addr[3:0]` selects the register: 0x0 status, 0x4 request on read and clear on write, 0x8 mask. Any other offset reads 0. `rdata` follows `addr` combinationally.
- R2: Reset is synchronous and active high. It zeroes every mask and the latched status. A request is the status ANDed with the mask, and a mask bit of 1 enables its source.
- R3: A latched-group status bit is set on a rising edge of its input and stays set until a 1 is written to that bit at the group's clear offset. When a set and a clear happen in the same cycle, the bit ends up set.
- R4: The status of the level, DMA and fast groups follows their inputs. Writes to the clear offset of these groups have no effect.
- R5: The groups are searched in the order level, then DMA, then latched. The first group with any request supplies the number.
- R6: Within the level group the winner order is bit 5, 2, 3, 7, 6, 0, 1, 4, giving number 8+bit.
- R7: Within the DMA group the winner order is bit 0, 1, 2, 3, 5, 6, 7, 4, giving number 16+bit.
- R8: Within the latched group the winner order is bit 7, 5, 3, 6, 2, 0, 1, 4, giving number bit.
- R9: `irq_valid` and `irq_line` are high exactly when any numbered group has a request. `irq_num` is 0 when there is none.
- R10: `fiq_out` is the OR of the masked fast requests. Fast sources never change `irq_num`, `irq_valid` or `irq_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Register address (group and offset) |
| wr_en | input | 1 | Write strobe, sampled on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| src_lat | input | 8 | Edge-latched sources, numbers 0–7 |
| src_lvl | input | 8 | Level sources, numbers 8–15 |
| src_dma | input | 8 | DMA channel requests, numbers 16–23 |
| src_fast | input | 8 | Fast-interrupt sources |
| irq_num | output | 5 | Winning interrupt number |
| irq_valid | output | 1 | A numbered request is pending |
| irq_line | output | 1 | Processor interrupt line |
| fiq_out | output | 1 | Fast-interrupt line |

## Verification
Damaged latched status shows up on the status read one edge after the bad update. It then appears in `irq_num` when no level or DMA request hides it. A misranked bit in any group's order table only shows for input patterns where two specific bits are both active. For that reason the bench sweeps every 8-bit pattern through each group. A mask or clear decode fault appears in the same cycle as the read that follows the write.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int GRP_W  = 8;
  localparam int IDX_W  = $clog2(GRP_W);
  localparam int NUM_W  = $clog2(3 * GRP_W);
  localparam int ADDR_W = 6;

  typedef enum logic [1:0] {
    GRP_LAT  = 2'd0,
    GRP_LVL  = 2'd1,
    GRP_DMA  = 2'd2,
    GRP_FAST = 2'd3
  } grp_e;

  localparam logic [3:0] OFS_STAT = 4'h0;
  localparam logic [3:0] OFS_REQ  = 4'h4;
  localparam logic [3:0] OFS_MASK = 4'h8;

  // Rank lists: entry k (bits k*IDX_W) is the k-th highest bit.
  localparam logic [GRP_W*IDX_W-1:0] RANK_LVL =
    {3'd4, 3'd1, 3'd0, 3'd6, 3'd7, 3'd3, 3'd2, 3'd5};
  localparam logic [GRP_W*IDX_W-1:0] RANK_DMA =
    {3'd4, 3'd7, 3'd6, 3'd5, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [GRP_W*IDX_W-1:0] RANK_LAT =
    {3'd4, 3'd1, 3'd0, 3'd2, 3'd6, 3'd3, 3'd5, 3'd7};
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
  import irq_ctrl_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);
  logic [W-1:0] prev_q;
  logic [W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= src;
      stat_q <= (stat_q & ~clr) | (src & ~prev_q);
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
#(
  parameter int W = GRP_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask,
  output logic [W-1:0] req
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  assign mask = mask_q;
  assign req  = stat & mask_q;
endmodule

// File: rtl/irq_rank_pick.sv
module irq_rank_pick
  import irq_ctrl_pkg::*;
#(
  parameter int                   W    = GRP_W,
  parameter int                   IW   = IDX_W,
  parameter int                   NW   = NUM_W,
  parameter logic [W*IW-1:0]      RANK = '0,
  parameter int                   BASE = 0
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [NW-1:0] num
);
  logic [IW-1:0] sel;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (req[RANK[k*IW +: IW]]) begin
        hit = 1'b1;
        sel = RANK[k*IW +: IW];
      end
    end
  end

  assign num = NW'(BASE) + NW'(sel);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [GRP_W-1:0]  wdata,
  output logic [GRP_W-1:0]  rdata,
  input  logic [GRP_W-1:0]  src_lat,
  input  logic [GRP_W-1:0]  src_lvl,
  input  logic [GRP_W-1:0]  src_dma,
  input  logic [GRP_W-1:0]  src_fast,
  output logic [NUM_W-1:0]  irq_num,
  output logic              irq_valid,
  output logic              irq_line,
  output logic              fiq_out
);
  localparam int NGRP = 4;

  grp_e       grp;
  logic [3:0] ofs;
  assign grp = grp_e'(addr[ADDR_W-1 -: 2]);
  assign ofs = addr[3:0];

  logic [GRP_W-1:0] clr_lat;
  assign clr_lat = (wr_en && grp == GRP_LAT && ofs == OFS_REQ) ? wdata : '0;

  logic [GRP_W-1:0] stat_lat;
  irq_edge_latch #(.W(GRP_W)) lat_i (
    .clk(clk), .rst(rst), .src(src_lat), .clr(clr_lat), .stat(stat_lat)
  );

  logic [NGRP-1:0][GRP_W-1:0] stat_g, mask_g, req_g;
  assign stat_g[GRP_LAT]  = stat_lat;
  assign stat_g[GRP_LVL]  = src_lvl;
  assign stat_g[GRP_DMA]  = src_dma;
  assign stat_g[GRP_FAST] = src_fast;

  for (genvar g = 0; g < NGRP; g++) begin : g_bank
    irq_bank #(.W(GRP_W)) bank_i (
      .clk(clk), .rst(rst), .stat(stat_g[g]),
      .mask_we(wr_en && grp == grp_e'(g) && ofs == OFS_MASK),
      .wdata(wdata), .mask(mask_g[g]), .req(req_g[g])
    );
  end

  logic [GRP_W-1:0] req_lat, req_lvl, req_dma;
  assign req_lat = req_g[GRP_LAT];
  assign req_lvl = req_g[GRP_LVL];
  assign req_dma = req_g[GRP_DMA];

  logic             hit_lat, hit_lvl, hit_dma;
  logic [NUM_W-1:0] num_lat, num_lvl, num_dma;

  irq_rank_pick #(.RANK(RANK_LVL), .BASE(GRP_W)) pick_lvl_i (
    .req(req_lvl), .hit(hit_lvl), .num(num_lvl));
  irq_rank_pick #(.RANK(RANK_DMA), .BASE(2*GRP_W)) pick_dma_i (
    .req(req_dma), .hit(hit_dma), .num(num_dma));
  irq_rank_pick #(.RANK(RANK_LAT), .BASE(0)) pick_lat_i (
    .req(req_lat), .hit(hit_lat), .num(num_lat));

  always_comb begin
    if (hit_lvl)      irq_num = num_lvl;
    else if (hit_dma) irq_num = num_dma;
    else if (hit_lat) irq_num = num_lat;
    else              irq_num = '0;
  end

  assign irq_valid = hit_lvl | hit_dma | hit_lat;
  assign irq_line  = |{req_lvl, req_dma, req_lat};
  assign fiq_out   = |req_g[GRP_FAST];

  always_comb begin
    unique case (ofs)
      OFS_STAT: rdata = stat_g[grp];
      OFS_REQ:  rdata = req_g[grp];
      OFS_MASK: rdata = mask_g[grp];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [NUM_W-1:0] irq_num,
  input logic             irq_valid,
  input logic             irq_line,
  input logic             fiq_out,
  input logic [GRP_W-1:0] src_fast,
  input logic [GRP_W-1:0] stat_lat,
  input logic [GRP_W-1:0] clr_lat,
  input logic [GRP_W-1:0] req_lvl,
  input logic [GRP_W-1:0] req_dma
);
  // R9
  valid_line_agree_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid == irq_line);

  // R9
  num_range_chk: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> irq_num < NUM_W'(3*GRP_W));

  // R10
  fast_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
    fiq_out |-> (src_fast != '0));

  // R3
  lat_drop_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((($past(stat_lat) & ~stat_lat) & ~$past(clr_lat)) == '0));

  // R5
  lat_only_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_num < NUM_W'(GRP_W)) |-> (req_lvl == '0 && req_dma == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .irq_num(irq_num), .irq_valid(irq_valid),
  .irq_line(irq_line), .fiq_out(fiq_out), .src_fast(src_fast),
  .stat_lat(stat_lat), .clr_lat(clr_lat), .req_lvl(req_lvl), .req_dma(req_dma)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] src_lat = '0, src_lvl = '0, src_dma = '0, src_fast = '0;
  logic [4:0] irq_num;
  logic       irq_valid, irq_line, fiq_out;

  always #2 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .src_lat(src_lat), .src_lvl(src_lvl), .src_dma(src_dma),
    .src_fast(src_fast), .irq_num(irq_num), .irq_valid(irq_valid),
    .irq_line(irq_line), .fiq_out(fiq_out)
  );

  typedef struct {
    bit         is_read;
    logic [7:0] d;
    logic       v;
    logic [4:0] n;
    logic       line;
    logic       fiq;
    string      tag;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  localparam int RK_LAT[8] = '{7, 5, 3, 6, 2, 0, 1, 4};
  localparam int RK_LVL[8] = '{5, 2, 3, 7, 6, 0, 1, 4};
  localparam int RK_DMA[8] = '{0, 1, 2, 3, 5, 6, 7, 4};

  function automatic int rank_pick(logic [7:0] r, int which);
    for (int k = 0; k < 8; k++) begin
      int b;
      b = (which == 0) ? RK_LAT[k] : (which == 1) ? RK_LVL[k] : RK_DMA[k];
      if (r[b]) return b;
    end
    return -1;
  endfunction

  // monitor: pops expected items and compares with live outputs
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (it.is_read) begin
        if (rdata !== it.d) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected %h", it.tag, rdata, it.d);
        end
      end else if (irq_valid !== it.v || irq_num !== it.n ||
                   irq_line !== it.line || fiq_out !== it.fiq) begin
        n_fail++;
        $display("FAIL %s: v/num/line/fiq=%b/%0d/%b/%b expected %b/%0d/%b/%b",
                 it.tag, irq_valid, irq_num, irq_line, fiq_out,
                 it.v, it.n, it.line, it.fiq);
      end
    end
  end

  task automatic push_out(string tag, logic v, logic [4:0] n, logic f);
    item_t it;
    it.is_read = 0; it.d = '0; it.v = v; it.n = n; it.line = v; it.fiq = f;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic push_rd(string tag, logic [5:0] a, logic [7:0] d);
    item_t it;
    addr = a;
    it.is_read = 1; it.d = d; it.v = 0; it.n = '0; it.line = 0; it.fiq = 0;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // expected outputs from request vectors (level, dma, latched)
  task automatic push_calc(string tag, logic [7:0] rl, logic [7:0] rd,
                           logic [7:0] ra, logic f);
    int b;
    b = rank_pick(rl, 1);
    if (b >= 0) begin push_out(tag, 1, 5'(8 + b), f); return; end
    b = rank_pick(rd, 2);
    if (b >= 0) begin push_out(tag, 1, 5'(16 + b), f); return; end
    b = rank_pick(ra, 0);
    if (b >= 0) begin push_out(tag, 1, 5'(b), f); return; end
    push_out(tag, 0, 5'd0, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state
    push_out("R2 reset outputs", 0, 0, 0);
    push_rd("R2 reset mask lat", 6'h08, 8'h00);
    push_rd("R2 reset mask fast", 6'h38, 8'h00);
    wr(6'h08, 8'hFF); wr(6'h18, 8'hFF); wr(6'h28, 8'hFF);
    push_rd("R1 mask readback lvl", 6'h18, 8'hFF);
    // R3: rising edges latch
    src_lat = 8'h12; @(negedge clk);
    push_rd("R3 lat status", 6'h00, 8'h12);
    push_out("R8 lat bit1 over bit4", 1, 5'd1, 0);
    wr(6'h04, 8'h02);
    push_rd("R3 clear bit1", 6'h00, 8'h10);
    push_out("R8 lat bit4 left", 1, 5'd4, 0);
    src_lat = 8'h00; @(negedge clk);
    push_rd("R3 held after input drop", 6'h00, 8'h10);
    // R3: set wins over same-cycle clear
    src_lat = 8'h01; wr(6'h04, 8'h01);
    push_rd("R3 set wins", 6'h00, 8'h11);
    push_out("R9 number 0 valid", 1, 5'd0, 0);
    push_rd("R1 bad offset", 6'h0C, 8'h00);
    // R4, R6: level group
    src_lvl = 8'h91; @(negedge clk);
    push_rd("R4 lvl status follows", 6'h10, 8'h91);
    push_out("R6 lvl bit7", 1, 5'd15, 0);
    wr(6'h14, 8'hFF);
    push_rd("R4 lvl clear ignored", 6'h10, 8'h91);
    push_out("R5 lvl over lat", 1, 5'd15, 0);
    // R7: DMA group
    src_lvl = 8'h00; src_dma = 8'h90; @(negedge clk);
    push_out("R7 dma bit7 over bit4", 1, 5'd23, 0);
    wr(6'h24, 8'hFF);
    push_rd("R4 dma clear ignored", 6'h20, 8'h90);
    src_dma = 8'h10; @(negedge clk);
    push_out("R7 dma bit4", 1, 5'd20, 0);
    wr(6'h28, 8'hEF);
    push_rd("R2 dma req masked", 6'h24, 8'h00);
    push_out("R5 falls to lat", 1, 5'd0, 0);
    // R10: fast group
    src_fast = 8'h04; @(negedge clk);
    push_out("R10 fast masked", 1, 5'd0, 0);
    wr(6'h38, 8'h04);
    push_out("R10 fast active, number unchanged", 1, 5'd0, 1);
    wr(6'h34, 8'hFF);
    push_rd("R4 fast clear ignored", 6'h30, 8'h04);
    push_rd("R2 fast request view", 6'h34, 8'h04);
    src_fast = 8'h00; wr(6'h04, 8'hFF);
    push_out("R9 none pending", 0, 5'd0, 0);
    // R8 sweep: all latched bits set, mask selects the request
    src_lat = 8'h00; @(negedge clk);
    src_lat = 8'hFF; @(negedge clk);
    for (int p = 0; p < 256; p++) begin
      wr(6'h08, 8'(p));
      push_calc("R8 lat sweep", 8'h00, 8'h00, 8'(p), 0);
    end
    // R6 sweep
    for (int p = 0; p < 256; p++) begin
      src_lvl = 8'(p); @(negedge clk);
      push_calc("R6 lvl sweep", 8'(p), 8'h00, 8'hFF, 0);
    end
    src_lvl = 8'h00;
    wr(6'h28, 8'hFF);
    // R7 sweep
    for (int p = 0; p < 256; p++) begin
      src_dma = 8'(p); @(negedge clk);
      push_calc("R7 dma sweep", 8'h00, 8'(p), 8'hFF, 0);
    end
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule